// File: doc/BRIEF.md
# Unaligned Byte Write Packer

This block turns a byte-granular write request into a sequence of aligned whole-word program requests. It is meant for a memory that can only be programmed one full word at a time. A request gives a starting byte address and a byte count. The payload bytes then arrive one per handshake on a byte stream. The block assembles each word and offers it with its aligned address on a word request port. It then waits for a per-word pass/fail response from the programming engine.

Programming can only clear bits. Any lane of a word that is not covered by the request is therefore filled with 0xFF, which leaves that location unchanged, and no read-modify-write is needed. The block keeps a running count of the request bytes that sit in successfully programmed words. When the request finishes it pulses a done strobe with that count and an error flag. A failed word stops the request at once.

Top module: `byte_word_packer`

## Requirements
- R1: Out of reset, req_ready is 1, while wr_valid, in_ready and done_valid are 0.
- R2: A request of length 0 raises done_valid in the cycle after it is accepted, with done_count 0 and done_err 0. No word request is issued.
- R3: Every word request address has its low log2(LANES) bits at zero. The first word goes to the start address rounded down to a word boundary.
- R4: In the first word, lanes below the start offset hold 0xFF. Request bytes then fill lanes upward from the offset, and any lanes still empty hold 0xFF.
- R5: After the first word, each further word carries the next LANES request bytes, at the address of the previous word plus LANES.
- R6: A final word holding fewer than LANES request bytes carries them in its lowest lanes, and its upper lanes hold 0xFF.
- R7: When the start and the last byte fall in the same word, exactly one padded word is issued.
- R8: Lane k occupies wr_data bits [8k+7:8k] and holds the byte whose address has low bits equal to k. Lane 0 is the lowest address (little-endian).
- R9: done_count equals the number of request bytes carried in words that were answered with success, and never exceeds the request length.
- R10: A failure response ends the request. done_valid and done_err follow in the next cycle, no further word is issued, and the failed word's bytes are not counted.
- R11: A pending word keeps wr_valid, wr_addr and wr_data stable until it is accepted. in_ready is low while a word is pending or awaiting its response. req_ready is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Starting byte address |
| req_len | input | LEN_W | Number of bytes to write |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken when high together with in_valid |
| in_data | input | 8 | Payload byte |
| wr_valid | output | 1 | Word program request offered |
| wr_ready | input | 1 | Word program request accepted |
| wr_addr | output | ADDR_W | Aligned byte address of the word |
| wr_data | output | 8*LANES | Word contents, lane 0 in the low byte |
| wr_resp_valid | input | 1 | Result of the accepted word is present |
| wr_resp_ok | input | 1 | 1 when the word programmed correctly |
| done_valid | output | 1 | One-cycle completion strobe |
| done_err | output | 1 | Request was stopped by a failed word |
| done_count | output | LEN_W | Bytes committed by the request |

## Verification
The hardest case to reach is a failure that lands on a middle or tail word. The request has to stop while payload bytes are still queued at the input, and the count has to exclude the failed word but keep the head bytes. The stimulus picks the failing word index at random for a share of the random requests. Directed requests fail the very first word and the last word of a multi-word transfer. Random start offsets, lengths and acceptance and response delays cover head-only, head-plus-tail and single-word shapes.

// File: rtl/pk_pkg.sv
package pk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ISSUE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } pk_state_e;

  // Bytes that go into one word: limited by the room above the first lane
  // and by what is left of the request.
  function automatic int unsigned span_bytes(input int unsigned first_lane,
                                             input int unsigned left,
                                             input int unsigned lanes);
    int unsigned room;
    room = lanes - first_lane;
    return (left < room) ? left : room;
  endfunction

endpackage

// File: rtl/pk_lane_fill.sv
module pk_lane_fill #(
  parameter int LANES = 4,
  localparam int LB   = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [LB-1:0]        first_lane_i,
  input  logic                 push_i,
  input  logic [7:0]           byte_i,
  output logic [8*LANES-1:0]   word_o
);

  logic [LB-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= first_lane_i;
    else if (push_i) ptr_q <= ptr_q + 1'b1;
  end

  // One byte register per lane; a load restores the erased-state pattern.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          lane_q <= 8'hFF;
      else if (load_i)                     lane_q <= 8'hFF;
      else if (push_i && ptr_q == LB'(g))  lane_q <= byte_i;
    end
    assign word_o[8*g +: 8] = lane_q;
  end

endmodule

// File: rtl/pk_seq.sv
module pk_seq
  import pk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  localparam int LB    = $clog2(LANES),
  localparam int CW    = $clog2(LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  input  logic              resp_valid,
  input  logic              resp_ok,
  output logic              done_valid,
  output logic              done_err,
  output logic [LEN_W-1:0]  done_count,
  output logic              load_o,
  output logic [LB-1:0]     first_lane_o,
  output logic              push_o,
  output logic              ev_word_ok,
  output logic              ev_word_fail
);

  pk_state_e         state_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [LEN_W-1:0]  left_q;
  logic [LEN_W-1:0]  committed_q;
  logic [CW-1:0]     need_q;
  logic [CW-1:0]     got_q;
  logic              err_q;

  logic              req_fire;
  logic              more_words;
  logic [LEN_W-1:0]  left_after;
  logic [CW-1:0]     need_first;
  logic [CW-1:0]     need_next;

  assign req_ready    = (state_q == ST_IDLE);
  assign in_ready     = (state_q == ST_FILL);
  assign wr_valid     = (state_q == ST_ISSUE);
  assign wr_addr      = waddr_q;
  assign done_valid   = (state_q == ST_DONE);
  assign done_err     = err_q;
  assign done_count   = committed_q;

  assign req_fire     = req_valid && req_ready;
  assign push_o       = in_valid && in_ready;
  assign ev_word_ok   = (state_q == ST_WAIT) && resp_valid && resp_ok;
  assign ev_word_fail = (state_q == ST_WAIT) && resp_valid && !resp_ok;

  assign left_after   = left_q - LEN_W'(need_q);
  assign more_words   = (left_after != '0);
  assign need_first   = CW'(span_bytes(32'(req_addr[LB-1:0]), 32'(req_len), LANES));
  assign need_next    = CW'(span_bytes(0, 32'(left_after), LANES));

  assign load_o       = (req_fire && req_len != '0) || (ev_word_ok && more_words);
  assign first_lane_o = (state_q == ST_IDLE) ? req_addr[LB-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      waddr_q     <= '0;
      left_q      <= '0;
      committed_q <= '0;
      need_q      <= '0;
      got_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_fire) begin
          waddr_q     <= {req_addr[ADDR_W-1:LB], {LB{1'b0}}};
          left_q      <= req_len;
          committed_q <= '0;
          err_q       <= 1'b0;
          got_q       <= '0;
          need_q      <= need_first;
          state_q     <= (req_len == '0) ? ST_DONE : ST_FILL;
        end
        ST_FILL: if (push_o) begin
          got_q <= got_q + 1'b1;
          if (got_q + 1'b1 == need_q) state_q <= ST_ISSUE;
        end
        ST_ISSUE: if (wr_ready) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (ev_word_ok) begin
            committed_q <= committed_q + LEN_W'(need_q);
            left_q      <= left_after;
            waddr_q     <= waddr_q + ADDR_W'(LANES);
            got_q       <= '0;
            need_q      <= need_next;
            state_q     <= more_words ? ST_FILL : ST_DONE;
          end else if (ev_word_fail) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  localparam int LB    = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [LEN_W-1:0]     req_len,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [8*LANES-1:0]   wr_data,
  input  logic                 wr_resp_valid,
  input  logic                 wr_resp_ok,
  output logic                 done_valid,
  output logic                 done_err,
  output logic [LEN_W-1:0]     done_count
);

  logic          load_w;
  logic [LB-1:0] first_lane_w;
  logic          push_w;
  logic          ev_word_ok;
  logic          ev_word_fail;

  pk_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .req_ready    (req_ready),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .wr_ready     (wr_ready),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .resp_valid   (wr_resp_valid),
    .resp_ok      (wr_resp_ok),
    .done_valid   (done_valid),
    .done_err     (done_err),
    .done_count   (done_count),
    .load_o       (load_w),
    .first_lane_o (first_lane_w),
    .push_o       (push_w),
    .ev_word_ok   (ev_word_ok),
    .ev_word_fail (ev_word_fail)
  );

  pk_lane_fill #(.LANES(LANES)) u_fill (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_w),
    .first_lane_i (first_lane_w),
    .push_i       (push_w),
    .byte_i       (in_data),
    .word_o       (wr_data)
  );

endmodule

// File: rtl/byte_word_packer_chk.sv
module byte_word_packer_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int LANES  = 4,
  localparam int LB    = $clog2(LANES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [LEN_W-1:0]   req_len,
  input logic               in_ready,
  input logic               wr_valid,
  input logic               wr_ready,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [8*LANES-1:0] wr_data,
  input logic               done_valid,
  input logic               done_err,
  input logic [LEN_W-1:0]   done_count,
  input logic               ev_word_ok,
  input logic               ev_word_fail
);

  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      len_q <= '0;
    else if (req_valid && req_ready) len_q <= req_len;
  end

  a_r2_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len == '0) |=>
      (done_valid && !done_err && done_count == '0 && !wr_valid));

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[LB-1:0] == '0));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (done_count <= len_q));

  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_fail |=> (done_valid && done_err && !wr_valid));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_valid && !wr_ready) |->
      (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r11_no_byte_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (!in_ready && !req_ready));

  a_r11_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_word_ok && ev_word_fail));

endmodule

bind byte_word_packer byte_word_packer_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_len      (req_len),
  .in_ready     (in_ready),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .done_valid   (done_valid),
  .done_err     (done_err),
  .done_count   (done_count),
  .ev_word_ok   (ev_word_ok),
  .ev_word_fail (ev_word_fail)
);

// File: tb/sim_byte_word_packer.sv
module sim_byte_word_packer;

  localparam int AW = 32;
  localparam int LW = 16;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [7:0]    in_data = '0;
  logic          wr_valid;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic          wr_resp_valid = 1'b0;
  logic          wr_resp_ok = 1'b0;
  logic          done_valid;
  logic          done_err;
  logic [LW-1:0] done_count;

  always #2 clk = ~clk;

  byte_word_packer #(.ADDR_W(AW), .LEN_W(LW), .LANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_resp_valid(wr_resp_valid), .wr_resp_ok(wr_resp_ok),
    .done_valid(done_valid), .done_err(done_err), .done_count(done_count)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Stimulus and capture state shared with the port agent below
  logic [7:0]  byteq[$];
  logic [31:0] cap_addr[$];
  logic [31:0] cap_data[$];
  int          fail_at = -1;
  bit          done_seen = 1'b0;
  bit          done_e;
  int          done_c;
  bit          hs_byte = 1'b0;
  bit          resp_pend = 1'b0;
  int          resp_dly = 0;
  int          words_acc = 0;
  bit          side_ok = 1'b1;

  // Port agent: acts only on falling edges, when all outputs are settled
  always @(negedge clk) begin
    if (hs_byte && byteq.size() > 0) void'(byteq.pop_front());
    in_valid = (byteq.size() > 0);
    in_data  = (byteq.size() > 0) ? byteq[0] : 8'h00;
    hs_byte  = in_valid && in_ready;

    wr_resp_valid = 1'b0;
    if (resp_pend) begin
      if (resp_dly == 0) begin
        wr_resp_valid = 1'b1;
        wr_resp_ok    = (words_acc - 1 != fail_at);
        resp_pend     = 1'b0;
      end else resp_dly--;
    end

    wr_ready = ($urandom % 3) != 0;
    if (wr_valid && wr_ready) begin
      cap_addr.push_back(wr_addr);
      cap_data.push_back(wr_data);
      words_acc++;
      resp_pend = 1'b1;
      resp_dly  = $urandom % 3;
    end

    if (done_valid) begin
      done_seen = 1'b1;
      done_e    = done_err;
      done_c    = int'(done_count);
      if (in_ready || wr_valid) side_ok = 1'b0;
    end
  end

  // Expected word image built byte by byte from the requirements
  task automatic run_req(input int start, input int len, input int fail_word);
    logic [31:0] exp_w[16];
    int          exp_n[16];
    int          nw;
    int          base;
    int          issued;
    int          cnt;
    logic [7:0]  pay[$];
    string       tag;
    int          guard;

    base = start / NL;
    nw   = (len == 0) ? 0 : ((start + len - 1) / NL) - base + 1;
    for (int w = 0; w < 16; w++) begin exp_w[w] = 32'hFFFF_FFFF; exp_n[w] = 0; end
    pay.delete();
    for (int i = 0; i < len; i++) begin
      int b, w, ln;
      logic [7:0] v;
      v  = 8'($urandom);
      pay.push_back(v);
      b  = start + i;
      w  = b / NL - base;
      ln = b % NL;
      exp_w[w][8*ln +: 8] = v;
      exp_n[w]++;
    end
    issued = (fail_word >= 0 && fail_word < nw) ? fail_word + 1 : nw;
    cnt = 0;
    for (int w = 0; w < issued; w++) if (w != fail_word) cnt += exp_n[w];

    @(negedge clk);
    byteq.delete();
    cap_addr.delete();
    cap_data.delete();
    words_acc = 0;
    fail_at   = fail_word;
    done_seen = 1'b0;
    side_ok   = 1'b1;
    foreach (pay[i]) byteq.push_back(pay[i]);
    req_addr  = AW'(start);
    req_len   = LW'(len);
    req_valid = 1'b1;
    guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!done_seen && guard < 2000) begin @(negedge clk); guard++; end
    if (!done_seen) begin
      chk(1'b0, "R9 watchdog: no done", 0, 1);
      return;
    end

    chk(cap_addr.size() == issued, (fail_word >= 0) ? "R10 word count" : "R5 word count",
        cap_addr.size(), issued);
    for (int w = 0; w < issued && w < cap_addr.size(); w++) begin
      if (nw == 1)           tag = "R7 single word data";
      else if (w == 0)       tag = "R4 head word data";
      else if (w == nw - 1)  tag = "R6 tail word data";
      else                   tag = "R5 middle word data";
      chk(cap_data[w] == exp_w[w], tag, cap_data[w], exp_w[w]);
      chk(cap_addr[w] == 32'((base + w) * NL), "R3 word address", cap_addr[w], (base + w) * NL);
    end
    chk(done_c == cnt, "R9 committed count", done_c, cnt);
    chk(done_e == (fail_word >= 0 && fail_word < nw), "R10 error flag", done_e,
        (fail_word >= 0 && fail_word < nw));
    chk(side_ok, "R11 no byte or word pending at done", 0, 1);
    if (len == 0) chk(cap_addr.size() == 0, "R2 zero length issues nothing", cap_addr.size(), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(req_ready && !wr_valid && !in_ready && !done_valid, "R1 reset state",
        {req_ready, wr_valid, in_ready, done_valid}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);

    run_req(8, 0, -1);     // R2
    run_req(5, 0, -1);     // R2 unaligned
    run_req(0, 4, -1);     // R8 aligned full word
    run_req(1, 2, -1);     // R7 inside one word
    run_req(3, 1, -1);     // R7 last lane only
    run_req(2, 2, -1);     // R7 ends on boundary
    run_req(1, 10, -1);    // R4 R5 R6
    run_req(4, 12, -1);    // R5 aligned run
    run_req(6, 9, 0);      // R10 first word fails
    run_req(2, 11, 3);     // R10 last word fails
    run_req(1, 14, 2);     // R10 middle word fails

    // R8 directed byte order
    begin
      @(negedge clk);
      byteq.delete(); cap_addr.delete(); cap_data.delete();
      words_acc = 0; fail_at = -1; done_seen = 1'b0;
      byteq.push_back(8'h11); byteq.push_back(8'h22);
      byteq.push_back(8'h33); byteq.push_back(8'h44);
      req_addr = 32'd16; req_len = 16'd4; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      for (int g = 0; g < 2000 && !done_seen; g++) @(negedge clk);
      chk(cap_data.size() == 1 && cap_data[0] == 32'h4433_2211, "R8 lane order",
          (cap_data.size() > 0) ? cap_data[0] : 32'h0, 32'h4433_2211);
    end

    for (int t = 0; t < 60; t++) begin
      int s, l, f;
      s = $urandom % 64;
      l = $urandom % 20;
      f = (($urandom % 4) == 0) ? int'($urandom % 6) : -1;
      run_req(s, l, f);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule